// File: doc/BRIEF.md
# Per-channel ramp sampling timing controller

This block sits inside one column channel of a display driver. The channel's analog input is a set of sampling capacitors. While a ramp shared by all channels rises one step per clock, the capacitors track it. A 6-bit count bus, also shared, tells every channel which ramp step is currently applied. At the start of each line the block captures an 8-bit pixel code. The upper six bits choose the ramp step to freeze. The lower two bits choose, for each capacitor, whether it freezes that step or the step after it.

There are three sampling enables. They are high while the capacitors track the ramp. Enable 0 always freezes the matched step n. Enable 1 is weighted one and enable 2 is weighted two. Each of them freezes step n+1 when its pixel bit is set, and step n when it is clear. An output amplifier that averages the three capacitors with weights 1, 1 and 2 then lands on n plus 0, 1/4, 2/4 or 3/4 of a step. A match flag goes low when the count reaches the coarse code.

Top module: `ramp_sample_timer`

## Requirements
- R1: After reset, the match flag and all three enables are high. They stay high for any count value until the first line-start strobe.
- R2: On a clock edge with the line-start strobe high, the block loads the pixel code. The match flag and all three enables are high after that edge, even if all of them were low before it.
- R3: The match flag goes low on the first clock edge after line start at which the sampled count equals pixel code bits [7:2]. This freezes level n.
- R4: Changes on the pixel code input between two line-start strobes have no effect on the outputs.
- R5: Enable 0 (qs[0]) goes low on the same edge as the match flag.
- R6: Enable k, for k = 1 and k = 2, takes pixel code bit k-1. When that bit is 0, enable k falls on the same edge as the match flag (level n). When that bit is 1, it falls exactly one clock later (level n+1).
- R7: Once the match flag or an enable is low, it stays low until the next line-start strobe. This holds even when the count wraps and equals the coarse code again.
- R8: Take a coarse code of 63. An enable set to freeze level n+1 still falls one clock after the match, while the count bus wraps to 0.
- R9: A count equal to the new coarse code on the line-start edge itself is ignored. Matching begins on the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the ramp count advances once per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Line-start strobe: loads the code and re-arms all outputs |
| pix_code | input | 8 | Pixel code; bits [7:2] are coarse, bits [1:0] are fine |
| ramp_count | input | 6 | Shared ramp step count |
| qs | output | 3 | Sampling enables: high means tracking, falling means frozen |
| qh | output | 1 | Match flag: high when idle, low once the count has matched |

## Verification
The bench builds the block with its default widths: an 8-bit code split 6/2, and three capacitors. At this size every one of the 256 pixel codes can be swept. Each code gets a full count sequence that runs past 63 and wraps. This exercises every fall position, including the wrap case of coarse code 63 and the re-match after a wrap. Separate passes cover the state before the first line and a line start that coincides with a matching count.

// File: rtl/ramp_sample_pkg.sv
package ramp_sample_pkg;

  typedef enum logic {
    PICK_LEVEL_N  = 1'b0,
    PICK_LEVEL_N1 = 1'b1
  } level_pick_e;

  function automatic level_pick_e pick_of(input logic fine_bit);
    return fine_bit ? PICK_LEVEL_N1 : PICK_LEVEL_N;
  endfunction

endpackage

// File: rtl/code_hold.sv
module code_hold #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] din,
  output logic [CODE_W-1:0] dout
);

  always_ff @(posedge clk) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= din;
  end

endmodule

// File: rtl/coarse_match.sv
module coarse_match #(
  parameter int COARSE_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_start,
  input  logic [COARSE_W-1:0] coarse,
  input  logic [COARSE_W-1:0] count,
  output logic                qh,
  output logic                hit,
  output logic                hit_late
);

  logic armed;

  function automatic logic codes_equal(input logic [COARSE_W-1:0] a,
                                       input logic [COARSE_W-1:0] b);
    return a == b;
  endfunction

  assign hit = armed && qh && !line_start && codes_equal(count, coarse);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      qh       <= 1'b1;
      hit_late <= 1'b0;
    end else if (line_start) begin
      armed    <= 1'b1;
      qh       <= 1'b1;
      hit_late <= 1'b0;
    end else begin
      hit_late <= hit;
      if (hit) qh <= 1'b0;
    end
  end

endmodule

// File: rtl/cap_gate.sv
module cap_gate
  import ramp_sample_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_start,
  input  level_pick_e pick,
  input  logic        hit,
  input  logic        hit_late,
  output logic        qs
);

  logic freeze_now;

  assign freeze_now = (pick == PICK_LEVEL_N) ? hit : hit_late;

  always_ff @(posedge clk) begin
    if (!rst_n)          qs <= 1'b1;
    else if (line_start) qs <= 1'b1;
    else if (freeze_now) qs <= 1'b0;
  end

endmodule

// File: rtl/ramp_sample_timer.sv
module ramp_sample_timer
  import ramp_sample_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int FINE_W   = 2,
  parameter int COARSE_W = CODE_W - FINE_W,
  parameter int NCAP     = FINE_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_start,
  input  logic [CODE_W-1:0]   pix_code,
  input  logic [COARSE_W-1:0] ramp_count,
  output logic [NCAP-1:0]     qs,
  output logic                qh
);

  logic [CODE_W-1:0]   held_code;
  logic [COARSE_W-1:0] coarse;
  logic [FINE_W-1:0]   fine;
  logic                hit;
  logic                hit_late;

  code_hold #(.CODE_W(CODE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(line_start),
    .din(pix_code), .dout(held_code)
  );

  assign coarse = held_code[CODE_W-1:FINE_W];
  assign fine   = held_code[FINE_W-1:0];

  coarse_match #(.COARSE_W(COARSE_W)) u_match (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .coarse(coarse), .count(ramp_count),
    .qh(qh), .hit(hit), .hit_late(hit_late)
  );

  for (genvar k = 0; k < NCAP; k++) begin : g_cap
    level_pick_e pick;
    if (k == 0) begin : g_base
      assign pick = PICK_LEVEL_N;
    end else begin : g_weighted
      assign pick = pick_of(fine[k-1]);
    end
    cap_gate u_gate (
      .clk(clk), .rst_n(rst_n), .line_start(line_start),
      .pick(pick), .hit(hit), .hit_late(hit_late), .qs(qs[k])
    );
  end

endmodule

// File: rtl/ramp_sample_timer_chk.sv
module ramp_sample_timer_chk #(
  parameter int CODE_W   = 8,
  parameter int FINE_W   = 2,
  parameter int COARSE_W = CODE_W - FINE_W,
  parameter int NCAP     = FINE_W + 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                line_start,
  input logic [COARSE_W-1:0] ramp_count,
  input logic [CODE_W-1:0]   held_code,
  input logic [NCAP-1:0]     qs,
  input logic                qh
);

  // R3
  qh_fall_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(qh) |-> $past(ramp_count) == $past(held_code[CODE_W-1:FINE_W]));

  // R5
  base_with_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(qs[0]) |-> $fell(qh));

  // R2
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (qh && (&qs)));

  // R7
  qh_stay_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!qh && !line_start) |=> !qh);

  // R6
  base_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qs != '1) |-> !qs[0]);

  for (genvar k = 0; k < NCAP; k++) begin : g_k
    // R7
    cap_stay_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!qs[k] && !line_start) |=> !qs[k]);
    if (k > 0) begin : g_w
      // R6
      near_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(qs[k]) && !held_code[k-1]) |-> $fell(qh));
      // R6
      far_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(qs[k]) && held_code[k-1]) |-> (!qh && !$past(qh)));
    end
  end

endmodule

bind ramp_sample_timer ramp_sample_timer_chk #(
  .CODE_W(CODE_W), .FINE_W(FINE_W), .COARSE_W(COARSE_W), .NCAP(NCAP)
) chk_i (
  .clk(clk), .rst_n(rst_n), .line_start(line_start),
  .ramp_count(ramp_count), .held_code(held_code), .qs(qs), .qh(qh)
);

// File: tb/ramp_sample_timer_test.sv
module ramp_sample_timer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_start = 1'b0;
  logic [7:0] pix_code = 8'h00;
  logic [5:0] ramp_count = 6'd0;
  logic [2:0] qs;
  logic       qh;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ramp_sample_timer uut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .pix_code(pix_code), .ramp_count(ramp_count), .qs(qs), .qh(qh)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {qh,qs} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset", {qh, qs}, 4'b1111);
    // R1: no line start yet, so no count value may trigger
    for (int i = 0; i < 64; i++) begin
      ramp_count = i[5:0];
      @(negedge clk);
      check("R1 idle", {qh, qs}, 4'b1111);
    end

    for (int c = 0; c < 256; c++) begin
      logic [7:0] cv;
      int n;
      cv = c[7:0];
      n = c >> 2;
      line_start = 1'b1;
      pix_code = cv;
      ramp_count = 6'd0;
      @(negedge clk);
      check("R2 rearm", {qh, qs}, 4'b1111);
      line_start = 1'b0;
      pix_code = ~cv; // R4 scramble during line
      for (int i = 0; i < 68; i++) begin
        logic [3:0] e;
        ramp_count = i[5:0];
        @(negedge clk);
        e[3] = !(i >= n);
        e[0] = !(i >= n);
        e[1] = !(i >= n + int'(cv[0]));
        e[2] = !(i >= n + int'(cv[1]));
        check("R3 R4 R5 R6 R7 sweep", {qh, qs}, e);
        if (n == 63 && i == 64)
          check("R8 wrap", {qh, qs}, 4'b0000);
      end
    end

    // R9: count equal to new coarse code on line-start edge is ignored
    line_start = 1'b1;
    pix_code = 8'h16;
    ramp_count = 6'd5;
    @(negedge clk);
    check("R9 ignored at load", {qh, qs}, 4'b1111);
    line_start = 1'b0;
    @(negedge clk);
    check("R9 match next", {qh, qs}, 4'b0100);
    ramp_count = 6'd6;
    @(negedge clk);
    check("R9 late cap", {qh, qs}, 4'b0000);

    finish_run();
  end

endmodule